// File: doc/BRIEF.md
# RGB to YCbCr Fixed-Point Converter

This block turns a stream of 8-bit RGB pixels into 8-bit luma (Y) and two chroma components (U, also called Cb, and V, also called Cr). It accepts one pixel on any clock cycle where the input strobe is high, and it returns the converted pixel with a matching strobe exactly two cycles later. The block applies no backpressure. Gaps in the input stream pass through as gaps in the output stream.

Each component is a dot product of the three inputs with constant 13-bit fixed-point weights. The signed sum is shifted right arithmetically by 13 bits, and a fixed offset is then added: 16 for luma and 128 for both chroma components. There is no clamping stage. The output is the low byte of the final sum, and it must match the integer equations bit for bit. The first pipeline stage registers the weighted sums. The second stage registers the shifted and offset bytes.

Top module: `rgb2ycc_top`

## Requirements
- R1: Y is the low byte of 16 + ((2104·R + 4130·G + 802·B) >>> 13).
- R2: U is the low byte of 128 + ((3598·B − 1217·R − 2382·G) >>> 13).
- R3: V is the low byte of 128 + ((3598·R − 3015·G − 583·B) >>> 13).
- R4: The shift of a negative chroma sum rounds toward minus infinity. Pure red (255,0,0) gives U = 90. Any grey input with level above zero gives U = 127, and every grey input gives V = 128.
- R5: No saturation is applied. For every 8-bit input the outputs lie in these ranges: Y in 16..235, U in 15..239, V in 16..239.
- R6: out_valid in a cycle equals in_valid sampled two rising edges earlier. The data presented with that strobe is the conversion of the pixel sampled with it.
- R7: A rising edge with rst high clears out_valid and every in-flight strobe. out_valid stays low until two edges after valid input resumes.
- R8: Back-to-back input yields one result per cycle with no loss, duplication or reordering. Cycles with in_valid low produce cycles with out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel strobe |
| in_r | input | 8 | Red component, unsigned |
| in_g | input | 8 | Green component, unsigned |
| in_b | input | 8 | Blue component, unsigned |
| out_valid | output | 1 | Output pixel strobe, two cycles after in_valid |
| out_y | output | 8 | Luma |
| out_u | output | 8 | Blue-difference chroma |
| out_v | output | 8 | Red-difference chroma |

## Verification
The checker assumes that the colour inputs are stable, known values whenever in_valid is high. It also assumes that rst is held for at least one edge before any data check is trusted, so its two-cycle history is only compared once two edges have passed since reset. The bench drives every input on the falling edge from fully known values, pulses reset before any traffic, and keeps pixel fields defined even in idle cycles. The range and grey-chroma properties can therefore rely on real history. Random traffic covers the whole 8-bit cube, including the corners and greys that reach the range limits.

// File: rtl/rgb2ycc_pkg.sv
package rgb2ycc_pkg;

    localparam int PIX_W   = 8;
    localparam int FRAC_W  = 13;
    localparam int SUM_W   = PIX_W + FRAC_W + 2;
    localparam int N_CH    = 3;

    localparam int OFS_LUMA   = 16;
    localparam int OFS_CHROMA = 128;

    typedef enum logic [1:0] {
        CH_LUMA = 2'd0,
        CH_BLUE = 2'd1,
        CH_RED  = 2'd2
    } chan_e;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] u;
        logic [PIX_W-1:0] v;
    } ycc_t;

    typedef logic signed [SUM_W-1:0] acc_t;

    // Weight of colour input 'src' (0=R,1=G,2=B) for output channel 'ch'.
    function automatic int weight(input int ch, input int src);
        int w;
        w = 0;
        case (ch)
            0: w = (src == 0) ? 2104  : (src == 1) ? 4130  : 802;
            1: w = (src == 0) ? -1217 : (src == 1) ? -2382 : 3598;
            default: w = (src == 0) ? 3598 : (src == 1) ? -3015 : -583;
        endcase
        return w;
    endfunction

    function automatic int offset(input int ch);
        return (ch == 0) ? OFS_LUMA : OFS_CHROMA;
    endfunction

endpackage

// File: rtl/rgb2ycc_dot.sv
module rgb2ycc_dot
    import rgb2ycc_pkg::*;
#(
    parameter int W_R = 0,
    parameter int W_G = 0,
    parameter int W_B = 0
) (
    input  rgb_t pix,
    output acc_t sum
);
    localparam int EXT_W = SUM_W - PIX_W;

    acc_t op_r, op_g, op_b;
    acc_t k_r, k_g, k_b;

    always_comb begin
        op_r = $signed({{EXT_W{1'b0}}, pix.r});
        op_g = $signed({{EXT_W{1'b0}}, pix.g});
        op_b = $signed({{EXT_W{1'b0}}, pix.b});
        k_r  = acc_t'(W_R);
        k_g  = acc_t'(W_G);
        k_b  = acc_t'(W_B);
        sum  = (k_r * op_r) + (k_g * op_g) + (k_b * op_b);
    end
endmodule

// File: rtl/rgb2ycc_norm.sv
module rgb2ycc_norm
    import rgb2ycc_pkg::*;
#(
    parameter int OFS = 0
) (
    input  acc_t             sum,
    output logic [PIX_W-1:0] byte_out
);
    acc_t scaled;
    acc_t biased;

    always_comb begin
        scaled   = sum >>> FRAC_W;
        biased   = scaled + acc_t'(OFS);
        byte_out = biased[PIX_W-1:0];
    end
endmodule

// File: rtl/rgb2ycc_top.sv
module rgb2ycc_top
    import rgb2ycc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_u,
    output logic [PIX_W-1:0] out_v
);
    rgb_t pix_in;
    acc_t mac_d [N_CH];
    acc_t mac_q [N_CH];
    logic [PIX_W-1:0] nrm_d [N_CH];
    logic             s1_valid;
    ycc_t             res_q;

    assign pix_in = '{r: in_r, g: in_g, b: in_b};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        rgb2ycc_dot #(
            .W_R(weight(c, 0)),
            .W_G(weight(c, 1)),
            .W_B(weight(c, 2))
        ) dot_i (
            .pix(pix_in),
            .sum(mac_d[c])
        );

        always_ff @(posedge clk) begin
            mac_q[c] <= mac_d[c];
        end

        rgb2ycc_norm #(
            .OFS(offset(c))
        ) norm_i (
            .sum(mac_q[c]),
            .byte_out(nrm_d[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        res_q.y <= nrm_d[CH_LUMA];
        res_q.u <= nrm_d[CH_BLUE];
        res_q.v <= nrm_d[CH_RED];
    end

    assign out_y = res_q.y;
    assign out_u = res_q.u;
    assign out_v = res_q.v;
endmodule

// File: rtl/rgb2ycc_checker.sv
module rgb2ycc_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_r,
    input logic [7:0] in_g,
    input logic [7:0] in_b,
    input logic       out_valid,
    input logic [7:0] out_y,
    input logic [7:0] out_u,
    input logic [7:0] out_v
);
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R7: reset empties the pipeline
    a_r7_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    // R6: two-edge strobe latency
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R5: result ranges without saturation
    a_r5_y_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235));
    a_r5_u_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_u >= 8'd15 && out_u <= 8'd239));
    a_r5_v_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_v >= 8'd16 && out_v <= 8'd239));

    // R4: grey input gives flat V and floor-rounded U
    a_r4_grey_chroma: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && out_valid && $past(in_r, 2) == $past(in_g, 2)
         && $past(in_g, 2) == $past(in_b, 2))
        |-> (out_v == 8'd128 && out_u == (($past(in_r, 2) == 8'd0) ? 8'd128 : 8'd127)));
endmodule

bind rgb2ycc_top rgb2ycc_checker chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v)
);

// File: tb/rgb2ycc_top_tb_top.sv
module rgb2ycc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_r = 8'd0, in_g = 8'd0, in_b = 8'd0;
    logic       out_valid;
    logic [7:0] out_y, out_u, out_v;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rgb2ycc_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    function automatic int yof(int r, int g, int b);
        return (16 + ((2104*r + 4130*g + 802*b) >>> 13)) & 255;
    endfunction
    function automatic int uof(int r, int g, int b);
        return (128 + ((3598*b - 1217*r - 2382*g) >>> 13)) & 255;
    endfunction
    function automatic int vof(int r, int g, int b);
        return (128 + ((3598*r - 3015*g - 583*b) >>> 13)) & 255;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: queue of expected results, one entry per edge
    typedef struct { bit v; int y; int u; int v_c; } exp_t;
    exp_t pipe[$];

    always @(posedge clk) begin
        exp_t e;
        e.v = in_valid; e.y = yof(in_r, in_g, in_b);
        e.u = uof(in_r, in_g, in_b); e.v_c = vof(in_r, in_g, in_b);
        if (rst) begin
            pipe.delete();
            e.v = 1'b0;
            pipe.push_back(e);
            pipe.push_back(e);
        end else begin
            pipe.push_back(e);
        end
        while (pipe.size() > 2) void'(pipe.pop_front());
    end

    always @(negedge clk) begin
        if (armed && !done && pipe.size() == 2) begin
            check("R6/R8 valid", int'(out_valid), int'(pipe[0].v));
            if (pipe[0].v && out_valid) begin
                check("R1 y", out_y, pipe[0].y);
                check("R2 u", out_u, pipe[0].u);
                check("R3 v", out_v, pipe[0].v_c);
                check("R5 y range", int'(out_y >= 16 && out_y <= 235), 1);
            end
        end
    end

    task automatic one_pixel(int r, int g, int b, int ey, int eu, int ev, string tag);
        in_valid = 1'b1; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({tag, " strobe"}, int'(out_valid), 1);
        check({tag, " y"}, out_y, ey);
        check({tag, " u"}, out_u, eu);
        check({tag, " v"}, out_v, ev);
        @(negedge clk);
        check({tag, " bubble R8"}, int'(out_valid), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        armed = 1'b1;
        check("R7 reset out_valid", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 idle after reset", int'(out_valid), 0);

        one_pixel(0, 0, 0, 16, 128, 128, "R1 black");
        one_pixel(255, 255, 255, 235, 127, 128, "R4 white");
        one_pixel(255, 0, 0, 81, 90, 239, "R4 red");
        one_pixel(0, 255, 0, 144, 53, 34, "R2 green");
        one_pixel(0, 0, 255, 40, 239, 109, "R3 blue");
        one_pixel(7, 7, 7, yof(7, 7, 7), 127, 128, "R4 grey");

        // R8: back-to-back then mixed traffic across the cube
        for (int i = 0; i < 3000; i++) begin
            in_valid = (i < 500) ? 1'b1 : 1'($urandom_range(0, 3) != 0);
            in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
            @(negedge clk);
        end

        // R7: reset with pixels in flight
        in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 flush", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 no stale strobe", int'(out_valid), 0);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule